// File: doc/BRIEF.md
# Extended Configuration Switch Executor

This block is the card-side engine that carries out a switch request against the extended configuration byte space. A 32-bit argument arrives with a one-cycle valid strobe. The block splits it into an access mode, a target byte index, a value byte and a command-set code, and checks that the request is legal. A legal request runs for a fixed number of busy cycles. On the last busy cycle it applies a read-modify-write to the addressed byte, or it changes the active command set.

An illegal request changes nothing. It raises an error flag, which stays high until the next request is accepted. Only two bytes of the space can be written: byte 183 holds the bus width and byte 185 holds the interface timing. Both are driven out continuously to the rest of the card. The read-only bytes (revision, card type, sector count) and the unimplemented bytes reject every write.

Control is a three-state machine:
- **ST_IDLE**: waiting for a request.
- **ST_BUSY**: the update is counting down.
- **ST_FAULT**: the last request was rejected.

Its transitions are:
- **ST_IDLE/ST_FAULT → ST_BUSY** on a legal strobe.
- **ST_IDLE/ST_FAULT → ST_FAULT** on an illegal strobe.
- **ST_BUSY → ST_IDLE** when the countdown expires and the update commits.
- Every state holds where it is otherwise.

Top module: `cfgsw_exec`

## Requirements
- R1: After reset:
  - `bus_width_o` = 0, `timing_o` = 0 and `cmd_set_o` = 0.
  - `busy_o` = 0 and `err_o` = 0.
- R2: Access mode 3 (argument bits [25:24] = 3) replaces the target byte (bits [23:16]) with the value byte (bits [15:8]). Target 183 is the bus width and target 185 is the timing byte.
- R3: Access mode 1 sets every bit of the target byte that is 1 in the value byte.
- R4: Access mode 2 clears every bit of the target byte that is 1 in the value byte.
- R5: Access mode 0 loads argument bits [2:0] into `cmd_set_o` and leaves both bytes unchanged, whatever the index and value fields hold.
- R6: A request with any 1 in bits [31:26] or bits [7:3] is rejected: `err_o` rises and no output byte or command set changes.
- R7: A mode 1, 2 or 3 request is rejected in the same way when its target is not 183 or 185. This covers the read-only indices 192, 196 and 212 to 215 and any unimplemented index.
- R8: A request whose resulting bus-width byte would exceed 2 is rejected, in any byte-changing mode. `bus_width_o` therefore never holds a value above 2, the legal codes being 0 for 1-bit, 1 for 4-bit and 2 for 8-bit.
- R9: Busy timing of a legal request:
  - `busy_o` is high for exactly BUSY_CYCLES cycles, starting the cycle after the strobe.
  - The new byte or command set appears in the same cycle that `busy_o` falls.
  - Outputs change at no other time.
- R10: A strobe while `busy_o` is high is ignored. It neither restarts the countdown nor alters the update in flight.
- R11: On a rejected request, `err_o` rises the cycle after the strobe and `busy_o` stays low. `err_o` holds until the next accepted strobe, and a legal one clears it as `busy_o` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| arg_valid_i | input | 1 | One-cycle strobe qualifying `arg_i` |
| arg_i | input | 32 | Switch request argument |
| busy_o | output | 1 | Update in progress |
| err_o | output | 1 | Last accepted request was illegal |
| bus_width_o | output | 8 | Current bus-width byte (index 183) |
| timing_o | output | 8 | Current timing byte (index 185) |
| cmd_set_o | output | 3 | Active command-set code |

## Verification
A chained vector table drives every access mode against both writable bytes. Each vector's result depends on the state the previous one left behind, so set, clear and replace are told apart by their effect on known bit patterns:
- Setting an already-set bit changes nothing.
- Clearing only removes the named bits.

Rejection is tried with each cause on its own:
- stray bits in the upper zero field;
- stray bits in the lower zero field;
- each class of read-only index;
- an out-of-range bus width reached both by replace and by set.

In every rejected case the bench checks that the previously written values survive. Directed tests measure the busy length, show that a second strobe during busy is dropped, and follow the error flag through hold and clear.

// File: rtl/cfgsw_pkg.sv
package cfgsw_pkg;

    localparam int ARG_W     = 32;
    localparam int BYTE_W    = 8;
    localparam int CS_W      = 3;
    localparam int IDX_W     = 8;

    // Byte indices that the rest of the card relies on
    localparam logic [IDX_W-1:0] IDX_BUS_WIDTH = 8'd183;
    localparam logic [IDX_W-1:0] IDX_TIMING    = 8'd185;

    // Largest legal bus-width code (0: 1-bit, 1: 4-bit, 2: 8-bit)
    localparam logic [BYTE_W-1:0] BW_CODE_MAX = 8'd2;

    typedef enum logic [1:0] {
        MODE_CMDSET  = 2'd0,
        MODE_SETBITS = 2'd1,
        MODE_CLRBITS = 2'd2,
        MODE_WRITE   = 2'd3
    } sw_mode_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_FAULT = 2'd2
    } sw_state_e;

    typedef struct packed {
        logic              legal;
        logic              to_cmdset;
        logic              tgt_timing;
        logic [BYTE_W-1:0] new_byte;
        logic [CS_W-1:0]   cs;
    } sw_req_t;

endpackage

// File: rtl/cfgsw_decode.sv
module cfgsw_decode
    import cfgsw_pkg::*;
(
    input  logic [ARG_W-1:0]  arg_i,
    input  logic [BYTE_W-1:0] cur_bw_i,
    input  logic [BYTE_W-1:0] cur_tm_i,
    output sw_req_t           req_o
);

    sw_mode_e          mode;
    logic [IDX_W-1:0]  idx;
    logic [BYTE_W-1:0] val;
    logic              zeros_ok;
    logic              hit_bw;
    logic              hit_tm;
    logic [BYTE_W-1:0] cur_byte;
    logic [BYTE_W-1:0] result;
    logic              bw_bad;

    always_comb begin
        mode     = sw_mode_e'(arg_i[25:24]);
        idx      = arg_i[23:16];
        val      = arg_i[15:8];
        zeros_ok = (arg_i[31:26] == '0) && (arg_i[7:3] == '0);
        hit_bw   = (idx == IDX_BUS_WIDTH);
        hit_tm   = (idx == IDX_TIMING);
        cur_byte = hit_tm ? cur_tm_i : cur_bw_i;

        unique case (mode)
            MODE_SETBITS: result = cur_byte | val;
            MODE_CLRBITS: result = cur_byte & ~val;
            MODE_WRITE:   result = val;
            default:      result = cur_byte;
        endcase

        bw_bad = hit_bw && (result > BW_CODE_MAX);

        req_o.to_cmdset  = (mode == MODE_CMDSET);
        req_o.tgt_timing = hit_tm;
        req_o.new_byte   = result;
        req_o.cs         = arg_i[2:0];
        req_o.legal      = zeros_ok &&
                           ((mode == MODE_CMDSET) || ((hit_bw || hit_tm) && !bw_bad));
    end

endmodule

// File: rtl/cfgsw_fsm.sv
module cfgsw_fsm
    import cfgsw_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic strobe_i,
    input  logic legal_i,
    output logic accept_o,
    output logic commit_o,
    output logic busy_o,
    output logic err_o
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(BUSY_CYCLES - 1);

    sw_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    // next state and counter
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE, ST_FAULT: begin
                if (strobe_i) begin
                    if (legal_i) begin
                        state_d = ST_BUSY;
                        cnt_d   = CNT_LOAD;
                    end else begin
                        state_d = ST_FAULT;
                    end
                end
            end
            ST_BUSY: begin
                if (cnt_q == '0) state_d = ST_IDLE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // outputs
    always_comb begin
        busy_o   = (state_q == ST_BUSY);
        err_o    = (state_q == ST_FAULT);
        accept_o = strobe_i && legal_i && (state_q != ST_BUSY);
        commit_o = (state_q == ST_BUSY) && (cnt_q == '0);
    end

    // R9 R10: countdown advances by one per cycle, never reloaded mid-flight
    busy_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_BUSY && cnt_q != '0) |=>
            (state_q == ST_BUSY && cnt_q == $past(cnt_q) - CNT_W'(1)));

endmodule

// File: rtl/cfgsw_regs.sv
module cfgsw_regs
    import cfgsw_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              accept_i,
    input  logic              commit_i,
    input  sw_req_t           req_i,
    output logic [BYTE_W-1:0] bw_o,
    output logic [BYTE_W-1:0] tm_o,
    output logic [CS_W-1:0]   cs_o
);

    sw_req_t pend_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            pend_q <= '0;
            bw_o   <= '0;
            tm_o   <= '0;
            cs_o   <= '0;
        end else begin
            if (accept_i) pend_q <= req_i;
            if (commit_i) begin
                if (pend_q.to_cmdset)       cs_o <= pend_q.cs;
                else if (pend_q.tgt_timing) tm_o <= pend_q.new_byte;
                else                        bw_o <= pend_q.new_byte;
            end
        end
    end

endmodule

// File: rtl/cfgsw_exec.sv
module cfgsw_exec
    import cfgsw_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        arg_valid_i,
    input  logic [31:0] arg_i,
    output logic        busy_o,
    output logic        err_o,
    output logic [7:0]  bus_width_o,
    output logic [7:0]  timing_o,
    output logic [2:0]  cmd_set_o
);

    sw_req_t req;
    logic    accept;
    logic    commit;

    cfgsw_decode u_decode (
        .arg_i    (arg_i),
        .cur_bw_i (bus_width_o),
        .cur_tm_i (timing_o),
        .req_o    (req)
    );

    cfgsw_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .strobe_i (arg_valid_i),
        .legal_i  (req.legal),
        .accept_o (accept),
        .commit_o (commit),
        .busy_o   (busy_o),
        .err_o    (err_o)
    );

    cfgsw_regs u_regs (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .accept_i (accept),
        .commit_i (commit),
        .req_i    (req),
        .bw_o     (bus_width_o),
        .tm_o     (timing_o),
        .cs_o     (cmd_set_o)
    );

    // R9
    idle_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |=> $stable({bus_width_o, timing_o, cmd_set_o}));

    // R11
    accept_outcome_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (arg_valid_i && !busy_o) |=> (busy_o != err_o));

    // R8
    bw_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_width_o <= BW_CODE_MAX);

    // R6 R7
    fault_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> $stable({bus_width_o, timing_o, cmd_set_o}));

endmodule

// File: tb/cfgsw_exec_tb_top.sv
module cfgsw_exec_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int BUSY_CYC   = 4;
    localparam int NVEC       = 18;

    typedef struct packed {
        logic [31:0] arg;
        logic        err;
        logic [7:0]  bw;
        logic [7:0]  tm;
        logic [2:0]  cs;
        logic [7:0]  req;
    } vec_t;

    // {zero6, mode, index, value, zero5, cmdset}; expected state is cumulative
    localparam vec_t VECS [NVEC] = '{
        {{6'd0, 2'd3, 8'd183, 8'h01, 5'd0, 3'd0}, 1'b0, 8'd1, 8'h00, 3'd0, 8'd2},  // R2
        {{6'd0, 2'd3, 8'd185, 8'h01, 5'd0, 3'd0}, 1'b0, 8'd1, 8'h01, 3'd0, 8'd2},  // R2
        {{6'd0, 2'd1, 8'd185, 8'h02, 5'd0, 3'd0}, 1'b0, 8'd1, 8'h03, 3'd0, 8'd3},  // R3
        {{6'd0, 2'd1, 8'd185, 8'h01, 5'd0, 3'd0}, 1'b0, 8'd1, 8'h03, 3'd0, 8'd3},  // R3 already set
        {{6'd0, 2'd2, 8'd185, 8'h01, 5'd0, 3'd0}, 1'b0, 8'd1, 8'h02, 3'd0, 8'd4},  // R4
        {{6'd0, 2'd1, 8'd183, 8'h02, 5'd0, 3'd0}, 1'b1, 8'd1, 8'h02, 3'd0, 8'd8},  // R8 via set
        {{6'd0, 2'd3, 8'd183, 8'h02, 5'd0, 3'd0}, 1'b0, 8'd2, 8'h02, 3'd0, 8'd2},  // R2
        {{6'd0, 2'd2, 8'd183, 8'h02, 5'd0, 3'd0}, 1'b0, 8'd0, 8'h02, 3'd0, 8'd4},  // R4
        {{6'd0, 2'd0, 8'd183, 8'h02, 5'd0, 3'd1}, 1'b0, 8'd0, 8'h02, 3'd1, 8'd5},  // R5
        {{6'd0, 2'd3, 8'd192, 8'h05, 5'd0, 3'd0}, 1'b1, 8'd0, 8'h02, 3'd1, 8'd7},  // R7
        {{6'd0, 2'd3, 8'd196, 8'h00, 5'd0, 3'd0}, 1'b1, 8'd0, 8'h02, 3'd1, 8'd7},  // R7
        {{6'd0, 2'd1, 8'd212, 8'h01, 5'd0, 3'd0}, 1'b1, 8'd0, 8'h02, 3'd1, 8'd7},  // R7
        {{6'd0, 2'd2, 8'd215, 8'h01, 5'd0, 3'd0}, 1'b1, 8'd0, 8'h02, 3'd1, 8'd7},  // R7
        {{6'd1, 2'd3, 8'd183, 8'h01, 5'd0, 3'd0}, 1'b1, 8'd0, 8'h02, 3'd1, 8'd6},  // R6
        {{6'd0, 2'd3, 8'd183, 8'h01, 5'd1, 3'd0}, 1'b1, 8'd0, 8'h02, 3'd1, 8'd6},  // R6
        {{6'd0, 2'd3, 8'd183, 8'h03, 5'd0, 3'd0}, 1'b1, 8'd0, 8'h02, 3'd1, 8'd8},  // R8
        {{6'd0, 2'd3, 8'd185, 8'hA5, 5'd0, 3'd0}, 1'b0, 8'd0, 8'hA5, 3'd1, 8'd2},  // R2
        {{6'd0, 2'd0, 8'd185, 8'hFF, 5'd0, 3'd0}, 1'b0, 8'd0, 8'hA5, 3'd0, 8'd5}   // R5
    };

    logic        clk;
    logic        rst_n;
    logic        vld;
    logic [31:0] arg;
    logic        busy;
    logic        err;
    logic [7:0]  bw;
    logic [7:0]  tm;
    logic [2:0]  cs;

    int compared;
    int mismatched;
    bit finished;

    cfgsw_exec #(.BUSY_CYCLES(BUSY_CYC)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .arg_valid_i (vld),
        .arg_i       (arg),
        .busy_o      (busy),
        .err_o       (err),
        .bus_width_o (bw),
        .timing_o    (tm),
        .cmd_set_o   (cs)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    // strobe one request; returns number of busy cycles, sampled at negedges
    task automatic do_sw(input logic [31:0] a, output int nbusy);
        @(negedge clk);
        arg = a;
        vld = 1'b1;
        @(negedge clk);
        vld   = 1'b0;
        nbusy = 0;
        while (busy && nbusy < 1000) begin
            nbusy++;
            @(negedge clk);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        int nb;
        compared   = 0;
        mismatched = 0;
        finished   = 1'b0;
        rst_n = 1'b0;
        vld   = 1'b0;
        arg   = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 bus width", 32'(bw), 0);
        chk("R1 timing", 32'(tm), 0);
        chk("R1 cmd set", 32'(cs), 0);
        chk("R1 busy", 32'(busy), 0);
        chk("R1 err", 32'(err), 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            string t;
            do_sw(VECS[i].arg, nb);
            t = $sformatf("R%0d vec%0d", VECS[i].req, i);
            chk({t, " err"}, 32'(err), 32'(VECS[i].err));
            chk({t, " busy cycles"}, nb, VECS[i].err ? 0 : BUSY_CYC);
            chk({t, " bus width"}, 32'(bw), 32'(VECS[i].bw));
            chk({t, " timing"}, 32'(tm), 32'(VECS[i].tm));
            chk({t, " cmd set"}, 32'(cs), 32'(VECS[i].cs));
        end

        // R9: output updates exactly as busy falls, not before
        @(negedge clk);
        arg = {6'd0, 2'd3, 8'd185, 8'h11, 5'd0, 3'd0};
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        for (int k = 0; k < BUSY_CYC; k++) begin
            chk("R9 busy during countdown", 32'(busy), 1);
            chk("R9 timing held while busy", 32'(tm), 32'hA5);
            @(negedge clk);
        end
        chk("R9 busy falls", 32'(busy), 0);
        chk("R9 timing committed", 32'(tm), 32'h11);

        // R10: second strobe while busy is dropped
        @(negedge clk);
        arg = {6'd0, 2'd3, 8'd185, 8'h22, 5'd0, 3'd0};
        vld = 1'b1;
        @(negedge clk);
        arg = {6'd0, 2'd3, 8'd185, 8'h33, 5'd0, 3'd0};
        @(negedge clk);
        vld = 1'b0;
        nb = 1;
        while (busy && nb < 1000) begin
            nb++;
            @(negedge clk);
        end
        chk("R10 busy not restarted", nb, BUSY_CYC);
        chk("R10 first request kept", 32'(tm), 32'h22);
        repeat (2) @(negedge clk);
        chk("R10 no second run", 32'(busy), 0);
        chk("R10 timing stable", 32'(tm), 32'h22);

        // R11: error holds, then a legal request clears it
        do_sw({6'd0, 2'd3, 8'd0, 8'h00, 5'd0, 3'd0}, nb);
        chk("R11 err raised", 32'(err), 1);
        chk("R11 no busy on reject", nb, 0);
        repeat (5) @(negedge clk);
        chk("R11 err held", 32'(err), 1);
        chk("R7 unimplemented index leaves timing", 32'(tm), 32'h22);
        @(negedge clk);
        arg = {6'd0, 2'd3, 8'd183, 8'h01, 5'd0, 3'd0};
        vld = 1'b1;
        @(negedge clk);
        vld = 1'b0;
        chk("R11 err cleared on accept", 32'(err), 0);
        chk("R11 busy on accept", 32'(busy), 1);
        while (busy) @(negedge clk);
        chk("R2 bus width after clear", 32'(bw), 1);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule